// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Tracker

This block sits behind one processor's interrupt interface. It takes the acknowledge request and the end-of-interrupt (EOI) request for that processor. It records which interrupt is running and at what priority. It also keeps a preemption history, so that completing a handler returns the processor to the interrupt it preempted. A separate selector supplies the best pending source and its priority. A lookup port gives the priority and trigger attributes of any source ID. The tracker sends back two requests: one asks to clear a pending bit after an acknowledge, and one asks to set a pending bit again for a level source that is still asserted.

The history is a linked chain. There is one link entry for each source, and it holds the ID that was running when that source was acknowledged. The ID 1023 means "nothing" and ends the chain.

Completing the running ID takes two cycles, because the link is followed through the lookup port to find the restored priority. Completing an ID that is not running walks the chain, reading one link per cycle. When the walk finds the entry that points at the completed ID, it replaces that entry with the completed ID's own link. This removes the completed ID from the middle of the chain.

The two strobes use valid/ready handshakes. A requester holds valid and its payload until it sees ready high at a clock edge. Both readies drop while a restore or a walk is in progress. When both strobes are valid in the same idle cycle, the acknowledge is taken first and the EOI waits.

Top module: `irq_ack_tracker`

## Requirements
- R1: After reset the running ID is 1023, the running priority is 0x100, both readies are high and no output pulse is active. Whenever the running ID is 1023, the running priority is 0x100.
- R2: An accepted acknowledge is refused in three cases: the pending ID is 1023, the pending ID is not below NUM_SRC, or the 8-bit pending priority is not strictly lower (more urgent) than the 9-bit running priority. A refused acknowledge produces a response pulse carrying 1023, leaves the running ID and priority unchanged, and raises no clear request.
- R3: A granted acknowledge produces a response pulse carrying the pending ID in the cycle after the accepting edge. From that cycle on, the running ID is the pending ID and the running priority is the pending priority.
- R4: A granted acknowledge raises a one-cycle clear request for the same ID, together with the response pulse. clr_all is high when the source uses the one-of-N model (pend_one_of_n = 1), so the clear applies to every processor. Otherwise it applies to this processor only.
- R5: An EOI is ignored if its ID is not below NUM_SRC, or if the running ID is 1023. An ignored EOI produces no re-pend pulse, leaves the running state unchanged and does not drop the readies.
- R6: A valid EOI raises a one-cycle re-pend request for its ID, in the cycle after the accepting edge. This happens only when all four lookup attributes of that ID are high: level-triggered, enabled, line high, and targets this processor.
- R7: Completing the running ID sets the running ID to that ID's link entry. It also sets the running priority to the looked-up priority of that entry, or to 0x100 when the entry is 1023. This takes effect two edges after the EOI is accepted.
- R8: Completing a non-running ID removes it from the chain without changing the running ID. Later completions then return to the ID it had preempted. An ID that is not in the chain leaves the chain unchanged.
- R9: Both readies are low while a restore or a chain walk is in progress. When ack_valid and eoi_valid are both high in an idle cycle, eoi_ready is low and only the acknowledge is taken.
- R10: The lookup port presents the EOI ID during the idle cycle in which an EOI is offered, and presents the running ID's link entry during a restore.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ack_valid | input | 1 | Acknowledge request |
| ack_ready | output | 1 | Acknowledge can be taken |
| pend_id | input | 10 | Best pending ID from the selector, 1023 if none |
| pend_prio | input | PRIO_W | Priority of pend_id, lower is more urgent |
| pend_one_of_n | input | 1 | pend_id uses the one-of-N model |
| ack_rsp_valid | output | 1 | One-cycle acknowledge response |
| ack_rsp_id | output | 10 | Acknowledged ID, or 1023 |
| eoi_valid | input | 1 | End-of-interrupt request |
| eoi_ready | output | 1 | EOI can be taken |
| eoi_id | input | 10 | ID being completed |
| lk_id | output | 10 | Lookup ID |
| lk_prio | input | PRIO_W | Priority of lk_id |
| lk_level | input | 1 | lk_id is level-triggered |
| lk_enabled | input | 1 | lk_id is enabled |
| lk_line | input | 1 | Input line of lk_id is high |
| lk_target | input | 1 | lk_id targets this processor |
| run_id | output | 10 | Running ID, 1023 if none |
| run_prio | output | PRIO_W+1 | Running priority, 0x100 if none |
| clr_valid | output | 1 | Clear-pending request pulse |
| clr_id | output | 10 | ID to clear |
| clr_all | output | 1 | Clear for every processor |
| repend_valid | output | 1 | Re-pend request pulse |
| repend_id | output | 10 | ID to mark pending again |

## Verification
A corrupted link entry shows up only at a later completion: run_id and run_prio return to the wrong interrupt, or to 1023 too early. The bench therefore checks the running state after every completion in a nested sequence, and not only after the final one. A wrong running priority shows up at the next acknowledge, as a grant that should have been refused or a refusal that should have been granted, in the cycle after the accepting edge. A walk that never terminates shows up as readies that stay low; the bench detects this within a bounded number of cycles.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NONE_ID = 10'd1023;
  typedef enum logic [1:0] {ST_IDLE, ST_RESTORE, ST_WALK} trk_state_e;
endpackage

// File: rtl/irq_ack_links.sv
module irq_ack_links #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 10,
  parameter int IDX_W   = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [ID_W-1:0]  wdata,
  input  logic [IDX_W-1:0] raddr_a,
  output logic [ID_W-1:0]  rdata_a,
  input  logic [IDX_W-1:0] raddr_b,
  output logic [ID_W-1:0]  rdata_b
);
  // one "preempted ID" per source; contents are undefined until written
  logic [ID_W-1:0] mem [NUM_SRC];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/irq_ack_grant.sv
module irq_ack_grant #(
  parameter int NUM_SRC = 64,
  parameter int ID_W    = 10,
  parameter int PRIO_W  = 8
) (
  input  logic [ID_W-1:0]   pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic [PRIO_W:0]   run_prio,
  output logic              grant
);
  localparam logic [ID_W-1:0] SRC_LIM = ID_W'(NUM_SRC);

  // 1023 is never below SRC_LIM, so "no pending" is refused here too
  assign grant = (pend_id < SRC_LIM) && ({1'b0, pend_prio} < run_prio);
endmodule

// File: rtl/irq_ack_tracker.sv
module irq_ack_tracker
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_valid,
  output logic              ack_ready,
  input  logic [9:0]        pend_id,
  input  logic [PRIO_W-1:0] pend_prio,
  input  logic              pend_one_of_n,
  output logic              ack_rsp_valid,
  output logic [9:0]        ack_rsp_id,
  input  logic              eoi_valid,
  output logic              eoi_ready,
  input  logic [9:0]        eoi_id,
  output logic [9:0]        lk_id,
  input  logic [PRIO_W-1:0] lk_prio,
  input  logic              lk_level,
  input  logic              lk_enabled,
  input  logic              lk_line,
  input  logic              lk_target,
  output logic [9:0]        run_id,
  output logic [PRIO_W:0]   run_prio,
  output logic              clr_valid,
  output logic [9:0]        clr_id,
  output logic              clr_all,
  output logic              repend_valid,
  output logic [9:0]        repend_id
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int STEP_W = $clog2(NUM_SRC + 1);
  localparam logic [STEP_W-1:0] STEP_MAX = STEP_W'(NUM_SRC);
  localparam int RP_W = PRIO_W + 1;
  localparam logic [RP_W-1:0] IDLE_PRIO = RP_W'(1) << PRIO_W;
  localparam logic [ID_W-1:0] SRC_LIM = ID_W'(NUM_SRC);

  trk_state_e       st_q;
  logic [ID_W-1:0]  run_id_q, cur_q, tgt_q;
  logic [RP_W-1:0]  run_prio_q;
  logic [STEP_W-1:0] steps_q;

  logic             grant, ack_fire, eoi_fire, eoi_live;
  logic             lk_we;
  logic [IDX_W-1:0] lk_waddr, rd_a_addr;
  logic [ID_W-1:0]  lk_wdata, link_a, link_b;

  irq_ack_grant #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_grant (
    .pend_id(pend_id), .pend_prio(pend_prio), .run_prio(run_prio_q), .grant(grant)
  );

  assign ack_ready = (st_q == ST_IDLE);
  assign eoi_ready = (st_q == ST_IDLE) && !ack_valid;
  assign ack_fire  = ack_ready && ack_valid;
  assign eoi_fire  = eoi_ready && eoi_valid;
  assign eoi_live  = (eoi_id < SRC_LIM) && (run_id_q != NONE_ID);

  // read port A follows the running ID in a restore, the walk cursor otherwise
  assign rd_a_addr = (st_q == ST_RESTORE) ? run_id_q[IDX_W-1:0] : cur_q[IDX_W-1:0];

  always_comb begin
    lk_we    = 1'b0;
    lk_waddr = pend_id[IDX_W-1:0];
    lk_wdata = run_id_q;
    if (ack_fire && grant) begin
      lk_we = 1'b1;
    end else if (st_q == ST_WALK && link_a == tgt_q && link_a != NONE_ID) begin
      lk_we    = 1'b1;
      lk_waddr = cur_q[IDX_W-1:0];
      lk_wdata = link_b;
    end
  end

  irq_ack_links #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .IDX_W(IDX_W)) u_links (
    .clk(clk), .we(lk_we), .waddr(lk_waddr), .wdata(lk_wdata),
    .raddr_a(rd_a_addr), .rdata_a(link_a),
    .raddr_b(tgt_q[IDX_W-1:0]), .rdata_b(link_b)
  );

  assign lk_id = (st_q == ST_IDLE) ? eoi_id : link_a;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      run_id_q      <= NONE_ID;
      run_prio_q    <= IDLE_PRIO;
      cur_q         <= '0;
      tgt_q         <= '0;
      steps_q       <= '0;
      ack_rsp_valid <= 1'b0;
      ack_rsp_id    <= NONE_ID;
      clr_valid     <= 1'b0;
      clr_id        <= '0;
      clr_all       <= 1'b0;
      repend_valid  <= 1'b0;
      repend_id     <= '0;
    end else begin
      ack_rsp_valid <= 1'b0;
      clr_valid     <= 1'b0;
      repend_valid  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ack_fire) begin
            ack_rsp_valid <= 1'b1;
            if (grant) begin
              ack_rsp_id <= pend_id;
              run_id_q   <= pend_id;
              run_prio_q <= {1'b0, pend_prio};
              clr_valid  <= 1'b1;
              clr_id     <= pend_id;
              clr_all    <= pend_one_of_n;
            end else begin
              ack_rsp_id <= NONE_ID;
            end
          end else if (eoi_fire && eoi_live) begin
            repend_valid <= lk_level && lk_enabled && lk_line && lk_target;
            repend_id    <= eoi_id;
            if (eoi_id == run_id_q) begin
              st_q <= ST_RESTORE;
            end else begin
              st_q    <= ST_WALK;
              cur_q   <= run_id_q;
              tgt_q   <= eoi_id;
              steps_q <= '0;
            end
          end
        end
        ST_RESTORE: begin
          run_id_q   <= link_a;
          run_prio_q <= (link_a == NONE_ID) ? IDLE_PRIO : {1'b0, lk_prio};
          st_q       <= ST_IDLE;
        end
        ST_WALK: begin
          if (link_a == NONE_ID || link_a == tgt_q || steps_q == STEP_MAX) begin
            st_q <= ST_IDLE;
          end else begin
            cur_q   <= link_a;
            steps_q <= steps_q + 1'b1;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_id   = run_id_q;
  assign run_prio = run_prio_q;
endmodule

// File: rtl/irq_ack_tracker_chk.sv
module irq_ack_tracker_chk #(
  parameter int NUM_SRC = 64,
  parameter int PRIO_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack_valid,
  input logic              ack_ready,
  input logic [9:0]        pend_id,
  input logic              eoi_valid,
  input logic              eoi_ready,
  input logic [9:0]        eoi_id,
  input logic [9:0]        run_id,
  input logic [PRIO_W:0]   run_prio,
  input logic              ack_rsp_valid,
  input logic [9:0]        ack_rsp_id,
  input logic              clr_valid,
  input logic [9:0]        clr_id,
  input logic              repend_valid
);
  localparam logic [9:0] NONE = 10'd1023;
  localparam logic [PRIO_W:0] IDLEP = (PRIO_W+1)'(1) << PRIO_W;

  // R1
  idle_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id == NONE) |-> (run_prio == IDLEP));

  // R2
  reject_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid && ack_ready && pend_id == NONE) |=>
      (ack_rsp_valid && ack_rsp_id == NONE && !clr_valid && $stable(run_id)));

  // R3
  grant_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rsp_valid && ack_rsp_id != NONE) |-> (run_id == ack_rsp_id));

  // R4
  clear_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_valid |-> (ack_rsp_valid && clr_id == ack_rsp_id));

  // R5
  eoi_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_valid && eoi_ready && eoi_id >= 10'(NUM_SRC)) |=>
      (!repend_valid && $stable(run_id) && ack_ready));

  // R9
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_ready |-> !eoi_ready);
endmodule

bind irq_ack_tracker irq_ack_tracker_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_ready(ack_ready),
  .pend_id(pend_id), .eoi_valid(eoi_valid), .eoi_ready(eoi_ready), .eoi_id(eoi_id),
  .run_id(run_id), .run_prio(run_prio), .ack_rsp_valid(ack_rsp_valid),
  .ack_rsp_id(ack_rsp_id), .clr_valid(clr_valid), .clr_id(clr_id),
  .repend_valid(repend_valid)
);

// File: tb/irq_ack_tracker_tb.sv
`timescale 1ns/1ps
module irq_ack_tracker_tb;
  localparam int NS = 64;
  localparam logic [9:0] NONE = 10'd1023;

  logic clk = 0, rst_n = 0;
  logic ack_valid = 0, ack_ready, pend_one_of_n = 0;
  logic [9:0] pend_id = NONE;
  logic [7:0] pend_prio = 8'hff;
  logic ack_rsp_valid; logic [9:0] ack_rsp_id;
  logic eoi_valid = 0, eoi_ready; logic [9:0] eoi_id = 0;
  logic [9:0] lk_id; logic [7:0] lk_prio;
  logic lk_level, lk_enabled, lk_line, lk_target;
  logic [9:0] run_id; logic [8:0] run_prio;
  logic clr_valid, clr_all, repend_valid;
  logic [9:0] clr_id, repend_id;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  // priority: higher ID is more urgent; re-pend when ID[1:0] == 3
  function automatic logic [7:0] pf(input logic [9:0] id);
    return 8'(255 - 3 * int'(id));
  endfunction
  always_comb begin
    lk_prio    = pf(lk_id);
    lk_level   = lk_id[0];
    lk_enabled = lk_id[1];
    lk_line    = 1'b1;
    lk_target  = 1'b1;
  end

  irq_ack_tracker #(.NUM_SRC(NS), .PRIO_W(8)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  logic        r_valid, r_clr, r_all;
  logic [9:0]  r_id, r_clrid;
  task automatic do_ack(input logic [9:0] id, input logic [7:0] p, input logic one);
    @(negedge clk);
    pend_id = id; pend_prio = p; pend_one_of_n = one; ack_valid = 1;
    @(posedge clk);
    @(negedge clk);
    ack_valid = 0;
    r_valid = ack_rsp_valid; r_id = ack_rsp_id;
    r_clr = clr_valid; r_clrid = clr_id; r_all = clr_all;
  endtask

  logic r_rep; logic [9:0] r_repid; bit r_busy;
  task automatic do_eoi(input logic [9:0] id);
    @(negedge clk);
    eoi_id = id; eoi_valid = 1;
    #1 chk(lk_id == id, "R10", lk_id, id);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 0;
    r_rep = repend_valid; r_repid = repend_id; r_busy = !ack_ready;
    for (int k = 0; k < 200 && !eoi_ready; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(run_id == NONE, "R1", run_id, NONE);
    chk(run_prio == 9'h100, "R1", run_prio, 256);
    chk(ack_ready && eoi_ready, "R1", ack_ready, 1);
    chk(!ack_rsp_valid && !clr_valid && !repend_valid, "R1", clr_valid, 0);

    // R5 EOI with nothing running
    do_eoi(10'd3);
    chk(!r_rep && run_id == NONE && !r_busy, "R5", r_rep, 0);

    // R2 pending none
    do_ack(NONE, 8'd0, 0);
    chk(r_valid && r_id == NONE && !r_clr, "R2", r_id, NONE);

    // R3 R4 R6 R7 sweep over every source
    for (int i = 0; i < NS; i++) begin
      logic [9:0] id = 10'(i);
      do_ack(id, pf(id), id[0]);
      chk(r_valid && r_id == id, "R3", r_id, id);
      chk(run_id == id && run_prio == {1'b0, pf(id)}, "R3", run_prio, pf(id));
      chk(r_clr && r_clrid == id && r_all == id[0], "R4", r_clrid, id);
      do_eoi(id);
      chk(r_rep == (id[1:0] == 2'd3) && (!r_rep || r_repid == id), "R6", r_rep, id[1:0] == 2'd3);
      chk(r_busy, "R9", r_busy, 1);
      chk(run_id == NONE && run_prio == 9'h100, "R7", run_id, NONE);
    end

    // nesting: 5 <- 9 <- 12 <- 33
    do_ack(10'd5, pf(10'd5), 0);
    do_ack(10'd9, pf(10'd9), 0);
    do_ack(10'd12, pf(10'd12), 0);
    do_ack(10'd33, pf(10'd33), 1);
    chk(run_id == 33 && run_prio == 9'(pf(10'd33)), "R3", run_id, 33);
    // R2 worse priority and equal priority refused
    do_ack(10'd20, pf(10'd20), 0);
    chk(r_id == NONE && !r_clr && run_id == 33, "R2", r_id, NONE);
    do_ack(10'd40, pf(10'd33), 0);
    chk(r_id == NONE && run_id == 33, "R2", r_id, NONE);
    // R5 out-of-range EOI
    do_eoi(10'd64);
    chk(!r_rep && run_id == 33 && !r_busy, "R5", run_id, 33);
    // R8 complete the middle entry
    do_eoi(10'd9);
    chk(run_id == 33 && run_prio == 9'(pf(10'd33)), "R8", run_id, 33);
    do_eoi(10'd50);
    chk(run_id == 33, "R8", run_id, 33);
    do_eoi(10'd33);
    chk(run_id == 12 && run_prio == 9'(pf(10'd12)), "R7", run_id, 12);
    do_eoi(10'd12);
    chk(run_id == 5 && run_prio == 9'(pf(10'd5)), "R8", run_id, 5);
    do_eoi(10'd5);
    chk(run_id == NONE && run_prio == 9'h100, "R7", run_prio, 256);

    // R9 simultaneous strobes: ack wins
    @(negedge clk);
    pend_id = 10'd7; pend_prio = pf(10'd7); ack_valid = 1;
    eoi_id = 10'd7; eoi_valid = 1;
    #1 chk(!eoi_ready && ack_ready, "R9", eoi_ready, 0);
    @(posedge clk);
    @(negedge clk);
    ack_valid = 0;
    chk(ack_rsp_id == 10'd7 && run_id == 10'd7 && !repend_valid, "R9", run_id, 7);
    @(posedge clk);
    @(negedge clk);
    eoi_valid = 0;
    for (int k = 0; k < 20 && !eoi_ready; k++) @(negedge clk);
    chk(run_id == NONE, "R9", run_id, NONE);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule